// File: doc/BRIEF.md
# Microwire Half-Duplex Serial Master

This block drives a half-duplex command/response serial link as its master. The host places 8-bit command bytes into a short transmit queue. For each byte the block pulls frame-select low and shifts the byte out most significant bit first, with the output driver enabled. It then releases the driver for a single serial clock, which gives the slave time to decode the command. After that it clocks in a reply whose length is set by a port, and places the reply in a receive queue.

The serial clock period is a whole number of system clocks. Every output is registered in the system clock domain. Received data passes through a synchronizer before it is sampled. When another command is already queued at the end of a frame, the next frame follows with no gap and frame-select stays low. A reply that arrives while the receive queue is full is discarded and raises a sticky error flag.

Top module: `mw_master`

## Requirements
- R1: While no frame is in progress, serial clock is 0, frame-select is 1, TX data is 0 and the active-low output enable is 1. After reset, busy, overrun and rx_valid are 0 and tx_ready is 1.
- R2: A frame starts when the transmit queue holds a byte. Frame-select falls, the oldest queued byte is taken, and its bit 7 appears on TX data with the output enable low and the serial clock low, all in the same cycle.
- R3: The 8 command bits go out MSB first, one bit per serial clock period. TX data changes only on a falling serial clock edge, so it is stable at every rising edge.
- R4: RX data is ignored during the command bits and during the turnaround clock, so only the reply bits reach the received word.
- R5: After the 8th command bit there is exactly one turnaround serial clock. The output enable is low only for the command bits and is high for the turnaround and the reply. A frame with reply length L has exactly 9+L rising serial clock edges.
- R6: The reply is sampled on rising serial clock edges, MSB first. It is stored right-justified in a 16-bit word with all bits above bit L-1 set to zero.
- R7: Frame-select returns high one serial clock period (prescale system clocks) after the rising edge that captures the last reply bit. The received word is pushed into the receive queue at that moment.
- R8: If the transmit queue is not empty when a frame ends, the next frame begins at once. Frame-select stays low between the two frames.
- R9: The serial clock high time and low time are each floor(prescale/2) system clocks. A prescale value below 6 is treated as 6. The prescale is latched at the start of each frame.
- R10: If the receive queue is full when a reply completes, the reply is discarded and overrun is set. Overrun stays set until overrun_clr is pulsed.
- R11: Busy is high from the falling edge of frame-select until frame-select returns high with the transmit queue empty. Busy stays high across back-to-back frames.
- R12: The reply length is latched at the start of each frame. Values below 4 are treated as 4 and values above 16 are treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prescale_i | input | PW | System clocks per serial clock period (even, at least 6) |
| resp_len_i | input | 5 | Reply length in bits (4 to 16) |
| tx_valid_i | input | 1 | Command byte offered to the transmit queue |
| tx_data_i | input | 8 | Command byte |
| tx_ready_o | output | 1 | Transmit queue can accept a byte |
| rx_valid_o | output | 1 | Receive queue holds a word |
| rx_data_o | output | 16 | Oldest received word, zero-extended |
| rx_ready_i | input | 1 | Pop the oldest received word |
| overrun_clr_i | input | 1 | Clear the overrun flag |
| overrun_o | output | 1 | Sticky flag: a reply was dropped |
| busy_o | output | 1 | A frame or a chain of frames is in progress |
| sclk_o | output | 1 | Serial clock |
| fss_n_o | output | 1 | Active-low frame select |
| txd_o | output | 1 | Serial command data |
| oe_n_o | output | 1 | Active-low output enable for the TX pad |
| rxd_i | input | 1 | Serial reply data from the slave |

## Verification
The bench builds the block with an 8-bit prescale, a four-entry transmit queue and a two-entry receive queue. With the shallow receive queue, three back-to-back frames are enough to reach the overrun path. The deeper transmit queue lets a chain of frames form without a gap. Prescale values below the floor and reply lengths outside 4 to 16 are both applied, so the clamping logic is exercised alongside the normal timing at several clock ratios.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;
  localparam int CMD_W    = 8;
  localparam int RESP_MAX = 16;
  localparam int RESP_MIN = 4;
  localparam int LEN_W    = 5;
  localparam int HALF_MIN = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_TURN,
    ST_RESP,
    ST_TAIL
  } mw_state_e;
endpackage

// File: rtl/mw_fifo.sv
`timescale 1ns/1ps
module mw_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] pop_data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o     = (cnt == FULLC);
  assign empty_o    = (cnt == '0);
  assign do_push    = push_i && !full_o;
  assign do_pop     = pop_i && !empty_o;
  assign pop_data_o = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/mw_sync.sv
`timescale 1ns/1ps
module mw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mw_engine.sv
`timescale 1ns/1ps
module mw_engine
  import mw_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PW-1:0]       prescale_i,
  input  logic [LEN_W-1:0]    resp_len_i,
  input  logic                tx_empty_i,
  input  logic [CMD_W-1:0]    tx_data_i,
  output logic                tx_pop_o,
  input  logic                rx_full_i,
  output logic                rx_push_o,
  output logic [RESP_MAX-1:0] rx_word_o,
  input  logic                rxd_s_i,
  input  logic                ovr_clr_i,
  output logic                sclk_o,
  output logic                fss_n_o,
  output logic                txd_o,
  output logic                oe_n_o,
  output logic                busy_o,
  output logic                ovr_o
);
  localparam logic [PW-1:0]    HMIN = PW'(HALF_MIN);
  localparam logic [LEN_W-1:0] LMIN = LEN_W'(RESP_MIN);
  localparam logic [LEN_W-1:0] LMAX = LEN_W'(RESP_MAX);
  localparam logic [LEN_W-1:0] LAST_CMD = LEN_W'(CMD_W - 1);

  mw_state_e            state;
  logic [PW-1:0]        hcnt, half_q, half_in;
  logic [LEN_W-1:0]     len_q, len_in, bcnt;
  logic                 ph;
  logic [CMD_W-1:0]     sh_tx;
  logic [RESP_MAX-1:0]  sh_rx;
  logic                 tick, frame_end, start_now;

  always_comb begin
    half_in = {1'b0, prescale_i[PW-1:1]};
    if (half_in < HMIN) half_in = HMIN;
    len_in = resp_len_i;
    if (len_in < LMIN)      len_in = LMIN;
    else if (len_in > LMAX) len_in = LMAX;
  end

  assign tick      = (hcnt == half_q - 1'b1);
  assign frame_end = (state == ST_TAIL) && tick && !ph;
  assign start_now = !tx_empty_i && ((state == ST_IDLE) || frame_end);
  assign tx_pop_o  = start_now;
  assign rx_push_o = frame_end && !rx_full_i;
  assign rx_word_o = sh_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      hcnt    <= '0;
      half_q  <= HMIN;
      len_q   <= LMIN;
      bcnt    <= '0;
      ph      <= 1'b0;
      sh_tx   <= '0;
      sh_rx   <= '0;
      sclk_o  <= 1'b0;
      fss_n_o <= 1'b1;
      txd_o   <= 1'b0;
      oe_n_o  <= 1'b1;
      busy_o  <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      if (frame_end && rx_full_i) ovr_o <= 1'b1;
      else if (ovr_clr_i)         ovr_o <= 1'b0;

      if (start_now) begin
        state   <= ST_CMD;
        sh_tx   <= tx_data_i;
        txd_o   <= tx_data_i[CMD_W-1];
        sh_rx   <= '0;
        half_q  <= half_in;
        len_q   <= len_in;
        hcnt    <= '0;
        bcnt    <= '0;
        ph      <= 1'b0;
        sclk_o  <= 1'b0;
        fss_n_o <= 1'b0;
        oe_n_o  <= 1'b0;
        busy_o  <= 1'b1;
      end else if (state != ST_IDLE) begin
        if (!tick) begin
          hcnt <= hcnt + 1'b1;
        end else begin
          hcnt <= '0;
          if (!ph) begin
            if (state == ST_TAIL) begin
              state   <= ST_IDLE;
              fss_n_o <= 1'b1;
              busy_o  <= 1'b0;
            end else begin
              sclk_o <= 1'b1;
              ph     <= 1'b1;
              if (state == ST_RESP) sh_rx <= {sh_rx[RESP_MAX-2:0], rxd_s_i};
            end
          end else begin
            sclk_o <= 1'b0;
            ph     <= 1'b0;
            case (state)
              ST_CMD: begin
                if (bcnt == LAST_CMD) begin
                  state  <= ST_TURN;
                  txd_o  <= 1'b0;
                  oe_n_o <= 1'b1;
                end else begin
                  sh_tx <= {sh_tx[CMD_W-2:0], 1'b0};
                  txd_o <= sh_tx[CMD_W-2];
                  bcnt  <= bcnt + 1'b1;
                end
              end
              ST_TURN: begin
                state <= ST_RESP;
                bcnt  <= '0;
              end
              ST_RESP: begin
                if (bcnt == len_q - 1'b1) state <= ST_TAIL;
                else                      bcnt  <= bcnt + 1'b1;
              end
              default: state <= state;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/mw_master.sv
`timescale 1ns/1ps
module mw_master
  import mw_pkg::*;
#(
  parameter int PW          = 8,
  parameter int TX_DEPTH    = 4,
  parameter int RX_DEPTH    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PW-1:0]       prescale_i,
  input  logic [LEN_W-1:0]    resp_len_i,
  input  logic                tx_valid_i,
  input  logic [CMD_W-1:0]    tx_data_i,
  output logic                tx_ready_o,
  output logic                rx_valid_o,
  output logic [RESP_MAX-1:0] rx_data_o,
  input  logic                rx_ready_i,
  input  logic                overrun_clr_i,
  output logic                overrun_o,
  output logic                busy_o,
  output logic                sclk_o,
  output logic                fss_n_o,
  output logic                txd_o,
  output logic                oe_n_o,
  input  logic                rxd_i
);
  logic                tx_full, tx_empty, tx_pop;
  logic [CMD_W-1:0]    tx_head;
  logic                rx_full, rx_empty, rx_push;
  logic [RESP_MAX-1:0] rx_word;
  logic                rxd_s;

  assign tx_ready_o = !tx_full;
  assign rx_valid_o = !rx_empty;

  mw_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) tx_q_i (
    .clk(clk), .rst(rst),
    .push_i(tx_valid_i), .push_data_i(tx_data_i),
    .pop_i(tx_pop), .pop_data_o(tx_head),
    .full_o(tx_full), .empty_o(tx_empty)
  );

  mw_fifo #(.W(RESP_MAX), .DEPTH(RX_DEPTH)) rx_q_i (
    .clk(clk), .rst(rst),
    .push_i(rx_push), .push_data_i(rx_word),
    .pop_i(rx_ready_i), .pop_data_o(rx_data_o),
    .full_o(rx_full), .empty_o(rx_empty)
  );

  mw_sync #(.STAGES(SYNC_STAGES)) rxd_sync_i (
    .clk(clk), .rst(rst), .d_i(rxd_i), .q_o(rxd_s)
  );

  mw_engine #(.PW(PW)) engine_i (
    .clk(clk), .rst(rst),
    .prescale_i(prescale_i), .resp_len_i(resp_len_i),
    .tx_empty_i(tx_empty), .tx_data_i(tx_head), .tx_pop_o(tx_pop),
    .rx_full_i(rx_full), .rx_push_o(rx_push), .rx_word_o(rx_word),
    .rxd_s_i(rxd_s), .ovr_clr_i(overrun_clr_i),
    .sclk_o(sclk_o), .fss_n_o(fss_n_o), .txd_o(txd_o), .oe_n_o(oe_n_o),
    .busy_o(busy_o), .ovr_o(overrun_o)
  );
endmodule

// File: rtl/mw_master_sva.sv
`timescale 1ns/1ps
module mw_master_sva (
  input logic clk,
  input logic rst,
  input logic sclk_o,
  input logic fss_n_o,
  input logic txd_o,
  input logic oe_n_o,
  input logic busy_o,
  input logic overrun_o,
  input logic overrun_clr_i
);
  p_idle_levels_r1: assert property (@(posedge clk) disable iff (rst)
    fss_n_o |-> (!sclk_o && !txd_o && oe_n_o));

  p_txd_stable_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> $stable(txd_o));

  p_oe_inside_frame_r5: assert property (@(posedge clk) disable iff (rst)
    !oe_n_o |-> !fss_n_o);

  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (overrun_o && !overrun_clr_i) |=> overrun_o);

  p_busy_follows_frame_r11: assert property (@(posedge clk) disable iff (rst)
    busy_o == !fss_n_o);
endmodule

bind mw_master mw_master_sva chk_i (
  .clk(clk), .rst(rst), .sclk_o(sclk_o), .fss_n_o(fss_n_o),
  .txd_o(txd_o), .oe_n_o(oe_n_o), .busy_o(busy_o),
  .overrun_o(overrun_o), .overrun_clr_i(overrun_clr_i)
);

// File: tb/mw_master_tb.sv
`timescale 1ns/1ps
module mw_master_tb_top;
  localparam int PW = 8;
  localparam int NV = 7;
  // {cmd[36:29], len[28:24], reply[23:8], prescale[7:0]}
  localparam logic [36:0] VEC [NV] = '{
    {8'hA5, 5'd8,  16'h00C3, 8'd6},
    {8'h7F, 5'd4,  16'hFFFA, 8'd6},
    {8'hFF, 5'd16, 16'hBEEF, 8'd8},
    {8'h01, 5'd12, 16'h0ABC, 8'd10},
    {8'h80, 5'd5,  16'h0015, 8'd2},
    {8'h3C, 5'd2,  16'h000F, 8'd6},
    {8'hC6, 5'd20, 16'h1234, 8'd6}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [PW-1:0] prescale = 8'd6;
  logic [4:0] resp_len = 5'd8;
  logic tx_valid = 1'b0, rx_ready = 1'b0, ovr_clr = 1'b0, rxd = 1'b1;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_valid, overrun, busy, sclk, fss_n, txd, oe_n;
  logic [15:0] rx_data;

  int n_chk = 0, n_fail = 0;
  int cur_len = 8;
  logic [15:0] cur_reply = '0;
  int rise_cnt = 0, frame_rises = 0, cmd_cnt = 0, slave_err = 0;
  int fss_rises = 0, busy_falls = 0;
  logic [7:0] cmd_sh = '0;
  logic [7:0] cmd_log [8];
  realtime t_rise = 0, t_high = 0, t_last_cap = 0, t_tail = 0;
  logic start_txd = 1'b0, start_oe = 1'b1, start_sclk = 1'b0;

  always #4 clk = ~clk;

  mw_master #(.PW(PW), .TX_DEPTH(4), .RX_DEPTH(2), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .prescale_i(prescale), .resp_len_i(resp_len),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_ready_i(rx_ready),
    .overrun_clr_i(ovr_clr), .overrun_o(overrun), .busy_o(busy),
    .sclk_o(sclk), .fss_n_o(fss_n), .txd_o(txd), .oe_n_o(oe_n), .rxd_i(rxd)
  );

  // slave model
  always @(posedge sclk) begin
    rise_cnt++;
    frame_rises++;
    t_rise = $realtime;
    if (rise_cnt <= 8) begin
      cmd_sh = {cmd_sh[6:0], txd};
      if (oe_n !== 1'b0) slave_err++;
      if (rise_cnt == 8) begin
        cmd_log[cmd_cnt % 8] = cmd_sh;
        cmd_cnt++;
      end
    end else if (oe_n !== 1'b1) slave_err++;
    if (rise_cnt == 9 + cur_len) begin
      t_last_cap = $realtime;
      rise_cnt = 0;
    end
  end

  always @(negedge sclk) begin
    t_high = $realtime - t_rise;
    if (rise_cnt >= 9 && rise_cnt <= 8 + cur_len) rxd = cur_reply[cur_len - 1 - (rise_cnt - 9)];
    else rxd = 1'b1;
  end

  always @(negedge fss_n) begin
    frame_rises = 0;
    rise_cnt = 0;
    #1;
    start_txd = txd;
    start_oe = oe_n;
    start_sclk = sclk;
  end

  always @(posedge fss_n) begin
    t_tail = $realtime - t_last_cap;
    fss_rises++;
  end

  always @(negedge busy) busy_falls++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_rx();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic wait_done();
    wait (busy == 1'b1);
    wait (busy == 1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(150000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    fss_rises = 0;
    busy_falls = 0;
    // R1 reset and idle state
    chk({fss_n, sclk, txd, oe_n} == 4'b1001, "R1 idle pins", {fss_n, sclk, txd, oe_n}, 4'b1001);
    chk({busy, overrun, rx_valid, tx_ready} == 4'b0001, "R1 reset status", {busy, overrun, rx_valid, tx_ready}, 4'b0001);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] cmd;
      int len, pre, half, elen;
      logic [15:0] exp_rx;
      cmd  = VEC[i][36:29];
      len  = int'(VEC[i][28:24]);
      pre  = int'(VEC[i][7:0]);
      half = (pre / 2 < 3) ? 3 : pre / 2;
      elen = (len < 4) ? 4 : (len > 16) ? 16 : len;
      exp_rx = VEC[i][23:8] & 16'((32'd1 << elen) - 1);
      prescale = VEC[i][7:0];
      resp_len = VEC[i][28:24];
      cur_len = elen;
      cur_reply = VEC[i][23:8];
      slave_err = 0;
      push(cmd);
      wait_done();
      // R2 frame start presents MSB with driver enabled
      chk(start_txd == cmd[7] && start_oe == 1'b0 && start_sclk == 1'b0, "R2 start",
          {start_txd, start_oe, start_sclk}, {cmd[7], 2'b00});
      // R3 command bits MSB first
      chk(cmd_log[(cmd_cnt - 1) % 8] == cmd, "R3 command", cmd_log[(cmd_cnt - 1) % 8], cmd);
      // R4/R5 enable window and no extra sampling
      chk(slave_err == 0, "R5 output enable window", slave_err, 0);
      chk(frame_rises == 9 + elen, "R5 edge count", frame_rises, 9 + elen);
      // R6 R12 reply right-justified, length clamped; R4 no stray bits
      chk(rx_valid && rx_data == exp_rx, "R6 R12 R4 reply word", rx_data, exp_rx);
      // R9 serial clock half period
      chk(int'(t_high) == half * 8, "R9 high time", int'(t_high), half * 8);
      // R7 frame-select rises one period after last capture
      chk(int'(t_tail) == 2 * half * 8, "R7 tail", int'(t_tail), 2 * half * 8);
      pop_rx();
    end

    // R8 R11 back-to-back frames
    prescale = 8'd6;
    resp_len = 5'd8;
    cur_len = 8;
    cur_reply = 16'h0055;
    fss_rises = 0;
    busy_falls = 0;
    push(8'h11);
    push(8'h22);
    wait_done();
    chk(fss_rises == 1, "R8 frame-select held low", fss_rises, 1);
    chk(busy_falls == 1, "R11 busy across frames", busy_falls, 1);
    chk(cmd_log[(cmd_cnt - 2) % 8] == 8'h11 && cmd_log[(cmd_cnt - 1) % 8] == 8'h22, "R8 command order",
        {cmd_log[(cmd_cnt - 2) % 8], cmd_log[(cmd_cnt - 1) % 8]}, 16'h1122);
    chk(rx_valid && rx_data == 16'h0055, "R8 first reply", rx_data, 16'h0055);
    pop_rx();
    chk(rx_valid && rx_data == 16'h0055, "R8 second reply", rx_data, 16'h0055);
    pop_rx();
    chk(!rx_valid, "R8 queue drained", rx_valid, 0);

    // R10 overrun with two-entry receive queue
    chk(!overrun, "R10 no overrun yet", overrun, 0);
    cur_reply = 16'h00A0;
    push(8'h31);
    cur_reply = 16'h00A0;
    push(8'h32);
    push(8'h33);
    wait_done();
    chk(overrun, "R10 overrun set", overrun, 1);
    repeat (3) @(negedge clk);
    chk(overrun, "R10 overrun sticky", overrun, 1);
    pop_rx();
    pop_rx();
    chk(!rx_valid, "R10 third reply dropped", rx_valid, 0);
    @(negedge clk);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    @(negedge clk);
    chk(!overrun, "R10 overrun cleared", overrun, 0);
    chk({fss_n, sclk, txd, oe_n, busy} == 5'b10010, "R1 idle after run", {fss_n, sclk, txd, oe_n, busy}, 5'b10010);

    finish_run();
  end
endmodule